// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers a small set of interrupt sources (by default five: bit 0 a timer-0 overflow, bits 1 and 2 two external edge inputs, bit 3 a timer-1 overflow and bit 4 a port-change event) and turns them into one request for a simple processor. Every source owns a pending flag, a mask (enable) bit and a priority bit. A control word carries three bits. One chooses between a single-level compatible mode and a two-level priority mode. The other two are global enables: a top (high/global) enable and a low (peripheral) enable.

The request and the vector address are formed combinationally from the enable values in force in the current cycle. A write that clears a mask bit or a global enable therefore blocks the request in the same cycle it is presented. The processor takes a request by pulsing `ack` while `irq` is high. The controller then clears the enable of the level taken and records that level. A `ret` strobe restores the enable of the most recently entered level. A high-priority request can interrupt low-priority service. The reverse cannot happen.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all flags, masks, priority bits and control bits read 0, `irq` is 0 and `vec` is 0.
- R2: A 1 on `src_set[i]` sets flag i at the next edge, and a 1 on `flag_clr[i]` clears it; a set wins over a clear. Mask and priority words load from their write ports at the next edge.
- R3: With control bit 2 (two-level mode) at 0, any flag that is 1 with its mask at 1 raises `irq` with `irq_hi`=1 and `vec`=0008h, provided control bit 1 (top enable) is 1; priority bits and control bit 0 have no effect.
- R4: In two-level mode, a pending unmasked source with priority bit 1 raises `irq` with `irq_hi`=1 and `vec`=0008h whenever control bit 1 is 1.
- R5: In two-level mode, a pending unmasked source with priority bit 0 raises `irq` with `irq_hi`=0 and `vec`=0018h only when control bits 1 and 0 are both 1, and only when no high-priority request exists; `vec` is 0 whenever `irq` is 0.
- R6: With control bit 1 at 0, `irq` is 0 in both modes, whatever the priority and mask bits.
- R7: A write presented on a mask, priority or control port takes effect on `irq` and `vec` in the same cycle; a control write clearing bit 1 gives `irq`=0 in that cycle.
- R8: `ack` while `irq`=1 clears control bit 1 at the next edge if the request was high-priority (`irq_hi`=1), else clears control bit 0; `ack` while `irq`=0 changes nothing.
- R9: While low-priority service is active (bit 0 cleared by a take, bit 1 still 1) a high-priority request is still issued; while high-priority service is active no request is issued.
- R10: `ret` restores control bit 1 if high-priority service is recorded, else control bit 0 if low-priority service is recorded, else changes nothing; `ret` in the same cycle as a take is ignored.
- R11: Clearing control bit 1 by a write while low-priority sources are pending leaves bit 1 at 0 and leaves bit 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | N | Per-source flag set pulses |
| flag_clr | input | N | Per-source flag clear pulses |
| mask_we | input | 1 | Mask word write strobe |
| mask_wdata | input | N | Mask word write data |
| prio_we | input | 1 | Priority word write strobe |
| prio_wdata | input | N | Priority word write data (1 = high) |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control write data: bit 2 two-level mode, bit 1 top enable, bit 0 low enable |
| ack | input | 1 | Processor takes the current request |
| ret | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Interrupt request (combinational) |
| irq_hi | output | 1 | Request is high priority |
| vec | output | ADDR_W | Vector address of the request, 0 when idle |
| flag_q | output | N | Pending flags |
| mask_q | output | N | Mask word |
| prio_q | output | N | Priority word |
| ctl_q | output | 3 | Control word, same bit layout as `ctl_wdata` |

## Verification
The bench targets the same-cycle masking window: a control write clearing the top enable while a low source is pending must drop `irq` at once, and a design that registered the enables would issue one stale vector there. It also walks nested service, where a low take followed by a high preemption and two returns must restore the enables in reverse order; a single-entry record would restore the wrong bit or both. Compatible mode is driven with low priority bits set to show that those bits and the low enable are ignored, since a design that honoured them would vector to 0018h or stay silent. Return strobes with nothing in service and takes with no request round out the cases where the control word must not move.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // Control word layout; bit positions are decoded by software.
  typedef struct packed {
    logic two_level;  // bit 2
    logic glb_hi;     // bit 1
    logic glb_lo;     // bit 0
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_set,
  input  logic [N-1:0] flag_clr,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic         prio_we,
  input  logic [N-1:0] prio_wdata,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] prio_q,
  output logic [N-1:0] mask_eff,
  output logic [N-1:0] prio_eff
);
  // One slice per source: flag, mask and priority storage.
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        mask_q[i] <= 1'b0;
        prio_q[i] <= 1'b0;
      end else begin
        flag_q[i] <= src_set[i] | (flag_q[i] & ~flag_clr[i]);
        if (mask_we) mask_q[i] <= mask_wdata[i];
        if (prio_we) prio_q[i] <= prio_wdata[i];
      end
    end
    // Write-through so a new mask acts in the cycle it is written.
    assign mask_eff[i] = mask_we ? mask_wdata[i] : mask_q[i];
    assign prio_eff[i] = prio_we ? prio_wdata[i] : prio_q[i];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int N = 5
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] mask_eff,
  input  logic [N-1:0] prio_eff,
  input  ctl_t         ctl_eff,
  output logic         req_hi,
  output logic         req_lo
);
  logic [N-1:0] pend;
  logic [N-1:0] hi_pend;
  logic [N-1:0] lo_pend;

  always_comb begin
    pend = flag & mask_eff;
    if (ctl_eff.two_level) begin
      hi_pend = pend & prio_eff;
      lo_pend = pend & ~prio_eff;
    end else begin
      hi_pend = pend;       // single level: everything uses the upper vector
      lo_pend = '0;
    end
    // The top enable gates both levels.
    req_hi = ctl_eff.glb_hi & (|hi_pend);
    req_lo = ctl_eff.glb_hi & ctl_eff.glb_lo & (|lo_pend) & ~req_hi;
  end
endmodule

// File: rtl/irq_svc_ctl.sv
module irq_svc_ctl
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             take_hi,
  input  logic             take_lo,
  input  logic             ret,
  output ctl_t             ctl_q,
  output ctl_t             ctl_eff
);
  logic svc_hi, svc_lo;
  ctl_t ctl_n;
  logic svc_hi_n, svc_lo_n;

  assign ctl_eff = ctl_we ? ctl_t'(ctl_wdata) : ctl_q;

  always_comb begin
    ctl_n    = ctl_eff;
    svc_hi_n = svc_hi;
    svc_lo_n = svc_lo;
    if (take_hi) begin
      ctl_n.glb_hi = 1'b0;
      svc_hi_n     = 1'b1;
    end else if (take_lo) begin
      ctl_n.glb_lo = 1'b0;
      svc_lo_n     = 1'b1;
    end else if (ret) begin
      if (svc_hi) begin
        ctl_n.glb_hi = 1'b1;
        svc_hi_n     = 1'b0;
      end else if (svc_lo) begin
        ctl_n.glb_lo = 1'b1;
        svc_lo_n     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      svc_hi <= svc_hi_n;
      svc_lo <= svc_lo_n;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int                N      = 5,
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HI_VEC = 16'h0008,
  parameter logic [ADDR_W-1:0] LO_VEC = 16'h0018
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      src_set,
  input  logic [N-1:0]      flag_clr,
  input  logic              mask_we,
  input  logic [N-1:0]      mask_wdata,
  input  logic              prio_we,
  input  logic [N-1:0]      prio_wdata,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              ack,
  input  logic              ret,
  output logic              irq,
  output logic              irq_hi,
  output logic [ADDR_W-1:0] vec,
  output logic [N-1:0]      flag_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      prio_q,
  output logic [CTL_W-1:0]  ctl_q
);
  logic [N-1:0] mask_eff, prio_eff;
  ctl_t         ctl_reg, ctl_eff;
  logic         req_hi, req_lo;

  irq_src_bank #(.N(N)) u_bank (
    .clk(clk), .rst(rst),
    .src_set(src_set), .flag_clr(flag_clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .prio_we(prio_we), .prio_wdata(prio_wdata),
    .flag_q(flag_q), .mask_q(mask_q), .prio_q(prio_q),
    .mask_eff(mask_eff), .prio_eff(prio_eff)
  );

  irq_arbiter #(.N(N)) u_arb (
    .flag(flag_q), .mask_eff(mask_eff), .prio_eff(prio_eff),
    .ctl_eff(ctl_eff), .req_hi(req_hi), .req_lo(req_lo)
  );

  irq_svc_ctl u_svc (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .take_hi(ack & req_hi), .take_lo(ack & req_lo), .ret(ret),
    .ctl_q(ctl_reg), .ctl_eff(ctl_eff)
  );

  assign irq    = req_hi | req_lo;
  assign irq_hi = req_hi;
  assign vec    = req_hi ? HI_VEC : (req_lo ? LO_VEC : '0);
  assign ctl_q  = ctl_reg;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int                N      = 5,
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HI_VEC = 16'h0008,
  parameter logic [ADDR_W-1:0] LO_VEC = 16'h0018
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      src_set,
  input logic              ctl_we,
  input logic [2:0]        ctl_wdata,
  input logic              ack,
  input logic              irq,
  input logic              irq_hi,
  input logic [ADDR_W-1:0] vec,
  input logic [N-1:0]      flag_q,
  input logic [2:0]        ctl_q
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (ctl_q == 3'b000 && flag_q == '0));

  a_r2_flag_set: assert property (@(posedge clk) disable iff (rst)
    (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set)));

  a_r3_single_level_hi: assert property (@(posedge clk) disable iff (rst)
    (!ctl_we && !ctl_q[2] && irq) |-> irq_hi);

  a_r5_vector_map: assert property (@(posedge clk) disable iff (rst)
    irq |-> (vec == (irq_hi ? HI_VEC : LO_VEC)));

  a_r5_idle_vec: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (vec == '0));

  a_r5_low_needs_both: assert property (@(posedge clk) disable iff (rst)
    (!ctl_we && irq && !irq_hi) |-> (ctl_q[2] && ctl_q[1] && ctl_q[0]));

  a_r6_top_gate: assert property (@(posedge clk) disable iff (rst)
    (!ctl_we && !ctl_q[1]) |-> !irq);

  a_r7_same_cycle_block: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_wdata[1]) |-> !irq);

  a_r8_take_hi: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_hi && ack) |=> !ctl_q[1]);

  a_r8_take_lo: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_hi && ack) |=> !ctl_q[0]);
endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .N(N), .ADDR_W(ADDR_W), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
) u_chk (
  .clk(clk), .rst(rst), .src_set(src_set), .ctl_we(ctl_we),
  .ctl_wdata(ctl_wdata), .ack(ack), .irq(irq), .irq_hi(irq_hi),
  .vec(vec), .flag_q(flag_q), .ctl_q(ctl_q)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int N = 5;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] src_set, flag_clr, mask_wdata, prio_wdata;
  logic mask_we, prio_we, ctl_we, ack, ret;
  logic [2:0] ctl_wdata;
  logic irq, irq_hi;
  logic [AW-1:0] vec;
  logic [N-1:0] flag_q, mask_q, prio_q;
  logic [2:0] ctl_q;

  always #10 clk = ~clk;  // 50 MHz

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .src_set(src_set), .flag_clr(flag_clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .prio_we(prio_we),
    .prio_wdata(prio_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ack(ack), .ret(ret), .irq(irq), .irq_hi(irq_hi), .vec(vec),
    .flag_q(flag_q), .mask_q(mask_q), .prio_q(prio_q), .ctl_q(ctl_q)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Stimulus for the next cycle.
  logic [N-1:0] d_sset, d_fclr, d_mwd, d_pwd;
  logic d_mwe, d_pwe, d_cwe, d_ack, d_ret;
  logic [2:0] d_cwd;

  // Bench model state.
  logic [N-1:0] m_flag, m_mask, m_prio;
  logic [2:0] m_ctl;
  logic m_svc_hi, m_svc_lo;
  string ctl_tag = "R1";

  // Observed at the last step.
  logic o_irq, o_hi;
  logic [AW-1:0] o_vec;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {irq, irq_hi} from flags and effective mask, priority and control.
  function automatic logic [1:0] exp_req(input logic [N-1:0] f, input logic [N-1:0] m,
                                         input logic [N-1:0] p, input logic [2:0] c);
    logic [N-1:0] pend;
    logic hi, lo;
    pend = f & m;
    if (c[2]) begin
      hi = c[1] & (|(pend & p));
      lo = c[1] & c[0] & (|(pend & ~p)) & ~hi;
    end else begin
      hi = c[1] & (|pend);
      lo = 1'b0;
    end
    return {hi | lo, hi};
  endfunction

  function automatic logic [AW-1:0] exp_vec(input logic [1:0] r);
    if (!r[1]) return '0;
    return r[0] ? 16'h0008 : 16'h0018;
  endfunction

  task automatic idle_in();
    d_sset = '0; d_fclr = '0; d_mwd = '0; d_pwd = '0;
    d_mwe = 0; d_pwe = 0; d_cwe = 0; d_ack = 0; d_ret = 0; d_cwd = '0;
  endtask

  task automatic step();
    logic [N-1:0] em, ep;
    logic [2:0] ec, nc;
    logic [1:0] r;
    string rtag;
    @(negedge clk);
    src_set = d_sset; flag_clr = d_fclr; mask_we = d_mwe; mask_wdata = d_mwd;
    prio_we = d_pwe; prio_wdata = d_pwd; ctl_we = d_cwe; ctl_wdata = d_cwd;
    ack = d_ack; ret = d_ret;
    #2;
    // State registers against the model.
    chk("R2 flags", 32'(flag_q), 32'(m_flag));
    chk("R2 mask", 32'(mask_q), 32'(m_mask));
    chk("R2 prio", 32'(prio_q), 32'(m_prio));
    chk(ctl_tag, 32'(ctl_q), 32'(m_ctl));
    em = d_mwe ? d_mwd : m_mask;
    ep = d_pwe ? d_pwd : m_prio;
    ec = d_cwe ? d_cwd : m_ctl;
    r = exp_req(m_flag, em, ep, ec);
    if (d_cwe && !d_cwd[1] && m_ctl[1]) rtag = "R7 request";
    else if (!ec[1]) rtag = "R6 request";
    else if (!ec[2]) rtag = "R3 request";
    else if (r[1] && !r[0]) rtag = "R5 request";
    else rtag = "R4 request";
    chk(rtag, {30'd0, irq, irq_hi}, {30'd0, r});
    chk(rtag, 32'(vec), 32'(exp_vec(r)));
    o_irq = irq; o_hi = irq_hi; o_vec = vec;
    // Model next state.
    nc = ec;
    ctl_tag = "R11 ctl";
    if (d_ack && r[1]) begin
      ctl_tag = "R8 ctl";
      if (r[0]) begin nc[1] = 0; m_svc_hi = 1; end
      else begin nc[0] = 0; m_svc_lo = 1; end
    end else if (d_ret) begin
      ctl_tag = "R10 ctl";
      if (m_svc_hi) begin nc[1] = 1; m_svc_hi = 0; end
      else if (m_svc_lo) begin nc[0] = 1; m_svc_lo = 0; end
    end
    @(posedge clk);
    m_flag = d_sset | (m_flag & ~d_fclr);
    m_mask = em; m_prio = ep; m_ctl = nc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_in();
    src_set = '0; flag_clr = '0; mask_we = 0; mask_wdata = '0; prio_we = 0;
    prio_wdata = '0; ctl_we = 0; ctl_wdata = '0; ack = 0; ret = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_flag = '0; m_mask = '0; m_prio = '0; m_ctl = '0; m_svc_hi = 0; m_svc_lo = 0;

    // R1: reset state
    step();
    chk("R1 outputs", {o_irq, 15'd0, o_vec}, 32'd0);
    chk("R1 state", {19'd0, flag_q, ctl_q, prio_q}, 32'd0);

    // R3: compatible mode, low-priority bits and low enable ignored
    idle_in(); d_mwe = 1; d_mwd = 5'b11111; d_pwe = 1; d_pwd = 5'b00010;
    d_cwe = 1; d_cwd = 3'b010; step();
    idle_in(); d_sset = 5'b00001; step();
    idle_in(); step();
    chk("R3 single level", {o_irq, o_hi, o_vec}, {2'b11, 16'h0008});
    // R8: take clears top enable
    idle_in(); d_ack = 1; step();
    idle_in(); step();
    chk("R8 take hi", 32'(ctl_q), 32'h0);
    chk("R8 blocked", 32'(o_irq), 32'h0);
    // R10: return restores it
    idle_in(); d_ret = 1; step();
    idle_in(); d_fclr = 5'b00001; step();
    chk("R10 restore hi", 32'(ctl_q), 32'h2);

    // Two-level: low request, take, high preempts
    idle_in(); d_cwe = 1; d_cwd = 3'b111; step();
    idle_in(); d_sset = 5'b00001; step();
    idle_in(); step();
    chk("R5 low vector", {o_irq, o_hi, o_vec}, {2'b10, 16'h0018});
    idle_in(); d_ack = 1; step();
    idle_in(); d_sset = 5'b00010; step();
    idle_in(); step();
    chk("R9 preempt low", {o_irq, o_hi, o_vec}, {2'b11, 16'h0008});
    idle_in(); d_ack = 1; step();
    idle_in(); step();
    chk("R9 no preempt of high", 32'(o_irq), 32'h0);
    idle_in(); d_ret = 1; step();
    idle_in(); d_ret = 1; step();
    idle_in(); d_fclr = 5'b00010; step();
    chk("R10 nested restore", 32'(ctl_q), 32'h7);

    // R11 / R7: clear top enable while low pending
    idle_in(); d_cwe = 1; d_cwd = 3'b101; step();
    chk("R7 same cycle", 32'(o_irq), 32'h0);
    idle_in(); step();
    chk("R11 enables after clear", 32'(ctl_q), 32'h5);
    chk("R6 masked", 32'(o_irq), 32'h0);
    idle_in(); d_ret = 1; step();
    idle_in(); d_ack = 1; step();
    idle_in(); step();
    chk("R10 idle return", 32'(ctl_q), 32'h5);

    // Constrained random traffic
    for (int k = 0; k < 3000; k++) begin
      idle_in();
      if ($urandom_range(3) == 0) d_sset = N'($urandom);
      if ($urandom_range(3) == 0) d_fclr = N'($urandom);
      if ($urandom_range(7) == 0) begin d_mwe = 1; d_mwd = N'($urandom); end
      if ($urandom_range(7) == 0) begin d_pwe = 1; d_pwd = N'($urandom); end
      if ($urandom_range(5) == 0) begin
        d_cwe = 1;
        d_cwd = {1'($urandom), ($urandom_range(3) != 0), ($urandom_range(3) != 0)};
      end
      d_ack = ($urandom_range(1) == 0);
      d_ret = ($urandom_range(4) == 0);
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule